// File: doc/BRIEF.md
# Infrared Carrier Mark-Space Modulator

This block shapes a carrier waveform into bursts for an infrared remote-control transmitter. Each modulation period has a mark interval, where the carrier (or a steady high level) is passed to the output, and a space interval, where the output is held low. Both intervals are counted in carrier periods. A `tick` input marks each carrier period, and the block reads the carrier itself on `carrier_in`.

Software programs the block through a byte-wide write port. It writes a 16-bit mark count and a 16-bit space count, each as a low byte and a high byte, and then a control byte that holds an enable bit and a two-bit mode. The working counter reads the buffers only when the block is idle or when a period ends. Software can therefore stage the next symbol while the current one plays out, and a one-clock end-of-period pulse tells it when to do so.

The timer is a 17-bit down-counter. It is loaded with a cleared sign bit and the mark count. Once the counter underflows, the gate closes. The bitwise complement of the counter's low 16 bits then counts the elapsed space ticks, and the period ends when that value equals the space count. A space count of zero therefore ends the period on the same tick that ends the mark. In FSK mode, a select line toggles at every period end, so the carrier generator alternates between two frequencies. The write port is a plain register strobe with no back-pressure: every strobed byte is taken in the cycle it is presented.

Top module: `ir_mark_space_mod`

## Requirements
- R1: After reset, `mod_out`, `fsk_sel` and `cycle_end` are low, all buffers read zero, and the block is disabled in time mode.
- R2: A cycle with `wr_en` high writes `wr_data` into one register, selected by `wr_addr`: 0 is the mark low byte, 1 the mark high byte, 2 the space low byte, 3 the space high byte, and 4 the control byte. In the control byte, bit 0 is enable and bits 2:1 are the mode (00 time, 01 baseband, 10 FSK, 11 behaves as time).
- R3: The counter advances only on clock edges where `tick` is high. A period starts with the gate open, and the gate stays open for mark+1 ticks.
- R4: After the mark, the gate stays closed for exactly space ticks, and then a new period starts. A space count of 0 produces no closed interval, so one mark follows the next directly.
- R5: In time mode, `mod_out` equals `carrier_in` while the gate is open and is 0 while the gate is closed.
- R6: In baseband mode, `mod_out` is 1 while the gate is open and 0 while it is closed, whatever `carrier_in` does.
- R7: In FSK mode, the output is gated as in time mode, and `fsk_sel` inverts at each period end. In the other modes, `fsk_sel` keeps its value while the block is enabled.
- R8: Buffer writes made during a period do not change that period. The working mark and space values are taken from the buffers only at a period end, or while the block is disabled.
- R9: While enable is 0, `mod_out` is 0 and `fsk_sel` is 0 from the next clock onward. A later enable starts a fresh period from the current buffers.
- R10: `cycle_end` is high for exactly the one clock cycle that follows each tick edge that ends a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Byte to write |
| carrier_in | input | 1 | Carrier waveform to be gated |
| tick | input | 1 | One pulse per carrier period |
| mod_out | output | 1 | Modulated output |
| fsk_sel | output | 1 | Carrier frequency select for FSK |
| cycle_end | output | 1 | One-clock pulse after each period end |

## Verification
Several properties are checked on every cycle. A period restart reloads a non-negative counter from the mark buffer. During the space interval, the complemented count stays below the space value. Every period end is followed by a `cycle_end` pulse. In FSK mode, `fsk_sel` inverts at each period end, and in the other modes it holds. A disabled block drives `mod_out` low. Only the bench scenarios can show the interval lengths themselves: mark+1 open ticks, space closed ticks, the zero-space case, stalled ticks, a mid-period buffer write taking effect one period later, and a restart after disable. The bench checks these against a behavioural tick-position model.

// File: rtl/ir_msm_pkg.sv
package ir_msm_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_TIME = 2'b00,
    MODE_BASE = 2'b01,
    MODE_FSK  = 2'b10,
    MODE_ALT  = 2'b11
  } msm_mode_e;
endpackage

// File: rtl/ir_msm_regs.sv
module ir_msm_regs
  import ir_msm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0]  mark_buf,
  output logic [CNT_W-1:0]  space_buf,
  output logic              enable,
  output msm_mode_e         mode
);
  localparam int NB       = CNT_W / BYTE_W;
  localparam int CTRL_IDX = 2 * NB;

  logic [BYTE_W-1:0] mark_b  [NB];
  logic [BYTE_W-1:0] space_b [NB];

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mark_b[b]  <= '0;
        space_b[b] <= '0;
      end else if (wr_en) begin
        if (wr_addr == ADDR_W'(b))      mark_b[b]  <= wr_data;
        if (wr_addr == ADDR_W'(NB + b)) space_b[b] <= wr_data;
      end
    end
    assign mark_buf[b*BYTE_W +: BYTE_W]  = mark_b[b];
    assign space_buf[b*BYTE_W +: BYTE_W] = space_b[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= 1'b0;
      mode   <= MODE_TIME;
    end else if (wr_en && wr_addr == ADDR_W'(CTRL_IDX)) begin
      enable <= wr_data[0];
      mode   <= msm_mode_e'(wr_data[2:1]);
    end
  end
endmodule

// File: rtl/ir_msm_timer.sv
module ir_msm_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic [CNT_W-1:0] mark_buf,
  input  logic [CNT_W-1:0] space_buf,
  output logic             gate,
  output logic             wrap
);
  logic [CNT_W:0]   cnt_q;
  logic [CNT_W:0]   cnt_dec;
  logic [CNT_W-1:0] spc_q;
  logic             match;

  assign cnt_dec = cnt_q - (CNT_W+1)'(1);
  assign match   = cnt_dec[CNT_W] && ((~cnt_dec[CNT_W-1:0]) == spc_q);
  assign wrap    = enable && tick && match;
  assign gate    = enable && !cnt_q[CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      spc_q <= '0;
    end else if (!enable || wrap) begin
      cnt_q <= {1'b0, mark_buf};
      spc_q <= space_buf;
    end else if (tick) begin
      cnt_q <= cnt_dec;
    end
  end

  a_r3_reload_positive: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (!cnt_q[CNT_W] && cnt_q[CNT_W-1:0] == $past(mark_buf)));

  a_r4_space_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cnt_q[CNT_W]) |-> ((~cnt_q[CNT_W-1:0]) < spc_q));
endmodule

// File: rtl/ir_msm_out.sv
module ir_msm_out
  import ir_msm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  msm_mode_e mode,
  input  logic      gate,
  input  logic      wrap,
  input  logic      carrier_in,
  output logic      mod_out,
  output logic      fsk_sel,
  output logic      cycle_end
);
  always_comb begin
    if (mode == MODE_BASE) mod_out = gate;
    else                   mod_out = gate && carrier_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsk_sel   <= 1'b0;
      cycle_end <= 1'b0;
    end else begin
      cycle_end <= wrap;
      if (!enable)                     fsk_sel <= 1'b0;
      else if (wrap && mode == MODE_FSK) fsk_sel <= !fsk_sel;
    end
  end

  a_r7_fsk_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wrap && mode == MODE_FSK) |=> (fsk_sel != $past(fsk_sel)));

  a_r7_fsk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && mode != MODE_FSK) |=> $stable(fsk_sel));

  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !mod_out);

  a_r10_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cycle_end);
endmodule

// File: rtl/ir_mark_space_mod.sv
module ir_mark_space_mod
  import ir_msm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              carrier_in,
  input  logic              tick,
  output logic              mod_out,
  output logic              fsk_sel,
  output logic              cycle_end
);
  logic [CNT_W-1:0] mark_buf;
  logic [CNT_W-1:0] space_buf;
  logic             enable;
  msm_mode_e        mode;
  logic             gate;
  logic             wrap;

  ir_msm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mark_buf(mark_buf), .space_buf(space_buf),
    .enable(enable), .mode(mode)
  );

  ir_msm_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .mark_buf(mark_buf), .space_buf(space_buf), .gate(gate), .wrap(wrap)
  );

  ir_msm_out u_out (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .gate(gate),
    .wrap(wrap), .carrier_in(carrier_in), .mod_out(mod_out),
    .fsk_sel(fsk_sel), .cycle_end(cycle_end)
  );

  a_r9_fsk_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !fsk_sel);
endmodule

// File: tb/ir_mark_space_mod_bench.sv
`timescale 1ns/1ps
module ir_mark_space_mod_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       carrier_in = 1'b0;
  logic       tick = 1'b0;
  logic       mod_out, fsk_sel, cycle_end;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  int    tick_div = 1;
  int    tick_cnt = 0;
  string cur_tag = "R1";
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  int m_mark_buf, m_space_buf, m_mark, m_space, m_pos, m_mode;
  bit m_en, m_fsk, m_cend;

  always #2.5 clk = ~clk;

  ir_mark_space_mod u_ir_mark_space_mod (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .carrier_in(carrier_in), .tick(tick),
    .mod_out(mod_out), .fsk_sel(fsk_sel), .cycle_end(cycle_end)
  );

  // tick and carrier stimulus
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    carrier_in <= lfsr[0];
    if (tick_div == 0) begin
      tick <= 1'b0;
    end else begin
      tick <= (tick_cnt == 0);
      tick_cnt <= (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
    end
  end

  // behavioural model: position of the tick within the period
  always @(posedge clk) begin
    bit cend;
    cyc++;
    cend = 0;
    if (!rst_n) begin
      m_mark_buf = 0; m_space_buf = 0; m_mark = 0; m_space = 0;
      m_pos = 0; m_mode = 0; m_en = 0; m_fsk = 0;
    end else begin
      if (!m_en) begin
        m_mark = m_mark_buf; m_space = m_space_buf; m_pos = 0; m_fsk = 0;
      end else if (tick) begin
        m_pos++;
        if (m_pos == m_mark + 1 + m_space) begin
          m_pos = 0; m_mark = m_mark_buf; m_space = m_space_buf;
          if (m_mode == 2) m_fsk = !m_fsk;
          cend = 1;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_mark_buf  = (m_mark_buf  & 32'hFF00) | int'(wr_data);
          3'd1: m_mark_buf  = (m_mark_buf  & 32'h00FF) | (int'(wr_data) << 8);
          3'd2: m_space_buf = (m_space_buf & 32'hFF00) | int'(wr_data);
          3'd3: m_space_buf = (m_space_buf & 32'h00FF) | (int'(wr_data) << 8);
          3'd4: begin m_en = wr_data[0]; m_mode = int'(wr_data[2:1]); end
          default: ;
        endcase
      end
    end
    m_cend = cend;
  end

  task automatic check1(string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", cur_tag, what, cyc, act, exp);
    end
  endtask

  // compare every cycle, away from the clock edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      logic gate_e, mod_e;
      gate_e = m_en && (m_pos <= m_mark);
      mod_e  = (m_mode == 1) ? gate_e : (gate_e && carrier_in);
      check1("mod_out", mod_out, mod_e);
      check1("fsk_sel", fsk_sel, m_fsk);
      check1("cycle_end", cycle_end, m_cend);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en <= 1'b1; wr_addr <= a; wr_data <= d;
    @(negedge clk);
    wr_en <= 1'b0;
  endtask

  task automatic prog(input int mark, input int space);
    wr(3'd0, mark[7:0]);  wr(3'd1, mark[15:8]);
    wr(3'd2, space[7:0]); wr(3'd3, space[15:8]);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL %s watchdog expired: actual=running expected=finished", cur_tag);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    run(4);
    rst_n <= 1'b1;
    @(negedge clk); #1;
    cur_tag = "R1";
    check1("reset mod_out", mod_out, 1'b0);
    check1("reset fsk_sel", fsk_sel, 1'b0);
    check1("reset cycle_end", cycle_end, 1'b0);

    cur_tag = "R5";                       // time mode, tick every 2 clocks
    tick_div = 2;
    prog(3, 2); wr(3'd4, 8'h01); run(80);

    cur_tag = "R6";                       // baseband
    tick_div = 1;
    prog(1, 3); wr(3'd4, 8'h03); run(60);

    cur_tag = "R4";                       // zero space: back-to-back marks
    prog(2, 0); wr(3'd4, 8'h01); run(40);

    cur_tag = "R2";                       // high bytes and reserved mode
    prog(16'h0102, 16'h0003); wr(3'd4, 8'h07); run(600);

    cur_tag = "R7";                       // FSK toggling, then hold in time mode
    prog(2, 1); wr(3'd4, 8'h05); run(60);
    wr(3'd4, 8'h01); run(40);

    cur_tag = "R8";                       // mid-period buffer write
    wr(3'd4, 8'h00); prog(20, 4); wr(3'd4, 8'h01); run(5);
    wr(3'd0, 8'd4); run(80);

    cur_tag = "R9";                       // disable mid-period, re-enable
    wr(3'd4, 8'h05); run(7);
    wr(3'd4, 8'h04); run(10);
    wr(3'd4, 8'h05); run(40);

    cur_tag = "R3";                       // sparse ticks and a stall
    tick_div = 5; prog(3, 2); wr(3'd4, 8'h01); run(120);
    tick_div = 0; run(30);

    cur_tag = "R10";                      // shortest period: pulse on every tick
    tick_div = 1; wr(3'd4, 8'h00); prog(0, 0); wr(3'd4, 8'h05); run(30);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule